// File: doc/BRIEF.md
# Selectable-Rate Periodic Interrupt Generator

This block raises a periodic interrupt at one of six rates taken from the prescaler chain of a timekeeping block. Software writes a control byte. A 3-bit code in that byte picks a rate. When the chosen prescaler tap makes a low-to-high transition, the block sets a sticky flag. While a valid code is selected, the flag also drives the interrupt line.

The prescaler taps come in as free-running square waves in the core clock domain. The block registers every tap and finds its rising edge before any selection is made. Because of this, moving the code onto a tap that is already high does not produce a false tick. Software acknowledges the interrupt by writing the control byte with the flag bit at 0. Writing 1 to the flag bit leaves the flag as it is.

Top module: `pit_periodic_gen`

## Requirements
- R1: A write (`wr_en` high) loads `wr_data[6:4]` into the rate code, and the new code is visible on `sel_o` after that clock edge.
- R2: Each code selects one prescaler tap: 1 selects `taps_i[0]` (256 Hz), 2 selects `taps_i[1]` (64 Hz), 3 selects `taps_i[2]` (16 Hz), 4 selects `taps_i[3]` (4 Hz), 5 selects `taps_i[4]` (2 Hz) and 6 selects `taps_i[5]` (1 Hz). A rising edge on the selected tap sets the flag. Edges on the other taps have no effect.
- R3: With code 0, rising edges on any of the taps leave the flag clear.
- R4: Code 7 is disabled in the same way as code 0, so no tap edge sets the flag.
- R5: The flag stays set until a write with `wr_data[7]` = 0. A write with `wr_data[7]` = 1 leaves the flag unchanged.
- R6: If a selected-tap rising edge arrives in the same cycle as a clearing write, the flag ends up set.
- R7: `irq_o` is high exactly when the flag is set and the code is between 1 and 6. A set flag under code 0 or code 7 keeps `irq_o` low.
- R8: Changing the code does not set the flag by itself, even when the newly selected tap is already high. The next rising edge of the new tap does set the flag.
- R9: A synchronous active-low reset clears the code and the flag, so `sel_o` = 0, `flag_o` = 0 and `irq_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| taps_i | input | 6 | Prescaler tap levels, bit 0 = 256 Hz up to bit 5 = 1 Hz |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data: bit 7 = flag, bits 6:4 = rate code |
| sel_o | output | 3 | Current rate code |
| flag_o | output | 1 | Sticky periodic flag |
| irq_o | output | 1 | Periodic interrupt request |

## Verification
The hardest case to reach is a change of code onto a tap that is already high. A design that selects the tap first and detects the edge afterwards would flag a false tick here. The stimulus holds all taps high while it writes a new code. It keeps them high for another cycle, then drops them, then raises only the newly chosen tap, and checks that the flag sets only on that last transition. A second hard case is a tick that lands in the same cycle as a clearing write. The stimulus reaches it by driving the tap edge together with the write strobe in one vector.

// File: rtl/pit_pkg.sv
// Package: shared sizes and field positions for the periodic interrupt generator.
// Assumes an 8-bit control byte with the flag in the top bit and the code just below it.
package pit_pkg;
    localparam int NUM_RATES = 6;   // number of prescaler taps offered
    localparam int SEL_W     = 3;   // width of the rate code
    localparam int REG_W     = 8;   // width of the control byte
    localparam int SEL_LSB   = 4;   // lowest bit of the code inside the byte
    localparam int FLAG_BIT  = 7;   // position of the sticky flag
endpackage

// File: rtl/pit_edge_bank.sv
// Module: pit_edge_bank
// Registers every prescaler tap and reports a one-cycle rise per tap.
// Assumes the taps are synchronous to clk. Edges are found before selection,
// so a change of selection can never look like an edge.
module pit_edge_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] taps,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_tap
        // Hold the previous level of this tap.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= taps[g];
        end
        assign rise[g] = taps[g] & ~prev_q[g];
    end
endmodule

// File: rtl/pit_rate_sel.sv
// Module: pit_rate_sel
// Decodes the rate code into per-tap enables and picks the tick of the chosen tap.
// Assumes code k (1..N) picks tap k-1. Code 0 and codes above N enable nothing.
module pit_rate_sel #(
    parameter int N     = 6,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [N-1:0]     rise,
    output logic             tick,
    output logic             active
);
    logic [N-1:0] en;

    for (genvar g = 0; g < N; g++) begin : g_dec
        assign en[g] = (sel == SEL_W'(g + 1));
    end

    // Gate the rises with the decoded enables.
    always_comb begin
        tick   = |(rise & en);
        active = |en;
    end

    AST_ONE_TAP:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0(en));  // R2
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                      (sel == '0 || sel > SEL_W'(N)) |-> !tick);                   // R4
endmodule

// File: rtl/pit_ctrl_reg.sv
// Module: pit_ctrl_reg
// Holds the rate code and the sticky flag of the control byte.
// Assumes a tick coinciding with a clearing write leaves the flag set.
module pit_ctrl_reg
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             tick,
    output logic [SEL_W-1:0] sel,
    output logic             flag
);
    logic [SEL_LSB-1:0] unused_low;
    assign unused_low = wr_data[SEL_LSB-1:0];

    // Load the rate code on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)     sel <= '0;
        else if (wr_en) sel <= wr_data[SEL_LSB +: SEL_W];
    end

    // Set on tick, clear on a write of 0 to the flag bit, tick wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                             flag <= 1'b0;
        else if (tick)                          flag <= 1'b1;
        else if (wr_en && !wr_data[FLAG_BIT])   flag <= 1'b0;
    end

    AST_SEL_LOAD:  assert property (@(posedge clk) disable iff (!rst_n)
                       wr_en |=> sel == $past(wr_data[SEL_LSB +: SEL_W]));          // R1
    AST_STICKY:    assert property (@(posedge clk) disable iff (!rst_n)
                       (flag && !(wr_en && !wr_data[FLAG_BIT])) |=> flag);          // R5
    AST_TICK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                       tick |=> flag);                                              // R6
endmodule

// File: rtl/pit_periodic_gen.sv
// Module: pit_periodic_gen (top)
// Periodic interrupt generator: finds tap edges, selects one by code, keeps a
// sticky flag and drives the interrupt while the code is valid.
// Assumes the taps are square waves synchronous to clk.
module pit_periodic_gen
    import pit_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RATES-1:0] taps_i,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [SEL_W-1:0]     sel_o,
    output logic                 flag_o,
    output logic                 irq_o
);
    logic [NUM_RATES-1:0] rise;
    logic                 tick;
    logic                 active;

    pit_edge_bank #(.N(NUM_RATES)) i_edges (
        .clk(clk), .rst_n(rst_n), .taps(taps_i), .rise(rise)
    );

    pit_rate_sel #(.N(NUM_RATES), .SEL_W(SEL_W)) i_sel (
        .clk(clk), .rst_n(rst_n), .sel(sel_o), .rise(rise),
        .tick(tick), .active(active)
    );

    pit_ctrl_reg i_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tick(tick), .sel(sel_o), .flag(flag_o)
    );

    // Drive the interrupt only while a valid rate is selected.
    always_comb irq_o = flag_o & active;

    AST_IRQ_OFF:    assert property (@(posedge clk) disable iff (!rst_n)
                        (sel_o == '0) |-> !irq_o);                                  // R7
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                        (!active && !flag_o) |=> !flag_o);                          // R3
    AST_RESET:      assert property (@(posedge clk)
                        !rst_n |=> (sel_o == '0 && !flag_o));                       // R9
endmodule

// File: tb/test_pit_periodic_gen.sv
module test_pit_periodic_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] taps_i = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] sel_o;
    logic       flag_o, irq_o;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    pit_periodic_gen i_pit_periodic_gen (
        .clk(clk), .rst_n(rst_n), .taps_i(taps_i), .wr_en(wr_en),
        .wr_data(wr_data), .sel_o(sel_o), .flag_o(flag_o), .irq_o(irq_o)
    );

    // vector: {tag[3:0], wr, wdata[7:0], taps[5:0], sel[2:0], flag, irq}
    localparam int NV = 25;
    localparam logic [23:0] VEC [NV] = '{
        {4'd1, 1'b1, 8'h10, 6'b000000, 3'd1, 1'b0, 1'b0},  // R1 load code 1
        {4'd2, 1'b0, 8'h00, 6'b000010, 3'd1, 1'b0, 1'b0},  // R2 other tap ignored
        {4'd2, 1'b0, 8'h00, 6'b000011, 3'd1, 1'b1, 1'b1},  // R2 256 Hz edge
        {4'd5, 1'b0, 8'h00, 6'b000000, 3'd1, 1'b1, 1'b1},  // R5 sticky
        {4'd5, 1'b1, 8'h90, 6'b000000, 3'd1, 1'b1, 1'b1},  // R5 write 1 keeps
        {4'd5, 1'b1, 8'h10, 6'b000000, 3'd1, 1'b0, 1'b0},  // R5 write 0 clears
        {4'd1, 1'b1, 8'h60, 6'b000000, 3'd6, 1'b0, 1'b0},  // R1 code 6
        {4'd2, 1'b0, 8'h00, 6'b000001, 3'd6, 1'b0, 1'b0},  // R2 256 Hz ignored
        {4'd2, 1'b0, 8'h00, 6'b100000, 3'd6, 1'b1, 1'b1},  // R2 1 Hz edge
        {4'd3, 1'b1, 8'h00, 6'b000000, 3'd0, 1'b0, 1'b0},  // R3 disable and clear
        {4'd3, 1'b0, 8'h00, 6'b111111, 3'd0, 1'b0, 1'b0},  // R3 all edges ignored
        {4'd3, 1'b0, 8'h00, 6'b000000, 3'd0, 1'b0, 1'b0},  // R3
        {4'd4, 1'b1, 8'h70, 6'b000000, 3'd7, 1'b0, 1'b0},  // R4 code 7
        {4'd4, 1'b0, 8'h00, 6'b111111, 3'd7, 1'b0, 1'b0},  // R4 all edges ignored
        {4'd8, 1'b1, 8'h30, 6'b111111, 3'd3, 1'b0, 1'b0},  // R8 switch onto high tap
        {4'd8, 1'b0, 8'h00, 6'b111111, 3'd3, 1'b0, 1'b0},  // R8 no false tick
        {4'd8, 1'b0, 8'h00, 6'b000000, 3'd3, 1'b0, 1'b0},  // R8
        {4'd8, 1'b0, 8'h00, 6'b000100, 3'd3, 1'b1, 1'b1},  // R8 real 16 Hz edge
        {4'd7, 1'b1, 8'h80, 6'b000000, 3'd0, 1'b1, 1'b0},  // R7 flag kept, irq masked
        {4'd5, 1'b1, 8'h40, 6'b000000, 3'd4, 1'b0, 1'b0},  // R5 clear, code 4
        {4'd6, 1'b1, 8'h40, 6'b001000, 3'd4, 1'b1, 1'b1},  // R6 tick beats clear
        {4'd5, 1'b1, 8'h50, 6'b000000, 3'd5, 1'b0, 1'b0},  // R5 clear, code 5
        {4'd2, 1'b0, 8'h00, 6'b010000, 3'd5, 1'b1, 1'b1},  // R2 2 Hz edge
        {4'd5, 1'b1, 8'h20, 6'b000000, 3'd2, 1'b0, 1'b0},  // R5 clear, code 2
        {4'd2, 1'b0, 8'h00, 6'b000010, 3'd2, 1'b1, 1'b1}   // R2 64 Hz edge
    };

    task automatic check(input int tag, input logic [2:0] es, input logic ef, input logic ei);
        checks++;
        if (sel_o !== es || flag_o !== ef || irq_o !== ei) begin
            errors++;
            $display("FAIL R%0d: sel/flag/irq actual %0d/%0b/%0b expected %0d/%0b/%0b",
                     tag, sel_o, flag_o, irq_o, es, ef, ei);
        end
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                check(9, 3'd0, 1'b0, 1'b0);              // R9 reset state
                rst_n = 1'b1;
                for (int i = 0; i < NV; i++) begin
                    wr_en   = VEC[i][19];
                    wr_data = VEC[i][18:11];
                    taps_i  = VEC[i][10:5];
                    @(negedge clk);
                    check(int'(VEC[i][23:20]), VEC[i][4:2], VEC[i][1], VEC[i][0]);
                end
                wr_en = 1'b0; taps_i = '0;
                // R9 reset during operation with flag set
                rst_n = 1'b0;
                @(negedge clk);
                check(9, 3'd0, 1'b0, 1'b0);
                rst_n = 1'b1;
                // R8 directed: code 1 while 256 Hz tap held high
                taps_i = 6'b000001;
                @(negedge clk);
                wr_en = 1'b1; wr_data = 8'h10;
                @(negedge clk);
                wr_en = 1'b0;
                @(negedge clk);
                check(8, 3'd1, 1'b0, 1'b0);
            end
            begin
                repeat (2000) @(posedge clk);
                checks++; errors++;
                $display("FAIL R9: watchdog expired, actual hung expected done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule